// File: doc/BRIEF.md
# Dual-Port Memory Bit-Flip Injector

This block is the application memory of a processor core, built so that faults can be planted in it while the core runs. It holds 256 words of 8-bit data in a synchronous two-port array. The core owns one port and uses it for its usual reads and writes. The other port belongs to a fault-injection controller. When a request arrives, the controller reads the word at the target address, XORs it with a flip mask and writes the result back. This read-modify-write runs beside the core's traffic and never stalls it.

A build-time switch chooses between two variants. The plain variant stores raw bytes. The hardened variant encodes every core write with a single-error-correcting Hamming code and decodes every core read, so a single flipped bit does not change the data the core sees. Running the same fault campaign on both variants shows how much the protection helps. In the hardened variant the mask acts on the stored codeword, which includes the parity bits.

Top module: `fim_mem_injector`

## Requirements
- R1: A core read (`a_en`=1, `a_we`=0) returns the stored word on `a_rdata` after the next rising clock edge. When a write to the same address lands on that edge, the read returns the value from before the write.
- R2: A core write (`a_en`=1, `a_we`=1) stores `a_wdata` at `a_addr` on the rising edge. A later read of that address returns the written byte.
- R3: A request on `inj_req` while idle latches `inj_addr` and `inj_mask`. The controller then spends one cycle reading the target word and one cycle writing it back. The written word is the read word XOR the mask. In the plain variant the mask has 8 bits, and its bit i flips data bit i.
- R4: `inj_busy` rises in the cycle after an accepted request and stays high for exactly two cycles. `inj_done` pulses for one cycle as `inj_busy` falls. A request made while `inj_busy` is high is ignored.
- R5: While an injection is in progress, core reads and writes to other addresses behave exactly as they do when no injection is running.
- R6: If the core writes the target address in the write-back cycle, the core's data is stored and the flip is lost. `inj_masked` then pulses together with `inj_done`. Otherwise `inj_masked` stays low.
- R7: If the core writes the target address in the read cycle, the flip is applied to the word the core just wrote.
- R8: With HARDEN=1 each byte is kept as a 12-bit codeword. Codeword bit p-1 holds Hamming position p, for p from 1 to 12. Positions 1, 2, 4 and 8 hold parity. Data bits 0 to 7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order. `inj_mask` is 12 bits wide and flips codeword bits. A core read returns the original byte whenever the stored codeword differs from a clean one in at most one bit.
- R9: While `rst` is high and just after it is released, `inj_busy`, `inj_done` and `inj_masked` are low and `a_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_en | input | 1 | Core port access enable |
| a_we | input | 1 | Core port write enable |
| a_addr | input | ADDR_W (8) | Core port address |
| a_wdata | input | DATA_W (8) | Core port write data |
| a_rdata | output | DATA_W (8) | Core port read data (decoded when hardened) |
| inj_req | input | 1 | Injection request, one-cycle pulse |
| inj_addr | input | ADDR_W (8) | Injection target address |
| inj_mask | input | WORD_W (12 hardened, 8 plain) | Flip mask applied to the stored word |
| inj_busy | output | 1 | Injection in progress |
| inj_done | output | 1 | Write-back finished, one-cycle pulse |
| inj_masked | output | 1 | Flip lost to a core write in the write-back cycle |

## Verification
The assertions check the handshake on every cycle. They check that `inj_busy` rises after an accepted request, that it lasts exactly two cycles and ends with a `done` pulse, and that `inj_masked` appears only with `done` and only when the core wrote the latched target during write-back. The data side can only be shown by the bench's scenarios: the flipped value in the plain variant, correction of single-bit and parity-bit flips in the hardened one, forwarding of a core write made during the read cycle, and core traffic left untouched during an injection. These scenarios are checked against a behavioural model of the stored data and the accumulated masks.

// File: rtl/fim_pkg.sv
package fim_pkg;

    typedef enum logic [1:0] {
        INJ_IDLE  = 2'd0,
        INJ_READ  = 2'd1,
        INJ_WRITE = 2'd2
    } inj_state_e;

    typedef struct packed {
        logic done;
        logic masked;
    } inj_flags_t;

    function automatic int par_bits(input int dw);
        int p;
        p = 0;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    function automatic int code_width(input int dw);
        return dw + par_bits(dw);
    endfunction

    function automatic bit is_pow2(input int v);
        return (v & (v - 1)) == 0;
    endfunction

endpackage

// File: rtl/fim_ham_enc.sv
module fim_ham_enc #(
    parameter int DATA_W = 8,
    parameter int CODE_W = fim_pkg::code_width(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);
    localparam int PAR_W = CODE_W - DATA_W;

    always_comb begin
        int  d;
        logic p;
        code = '0;
        d    = 0;
        for (int pos = 1; pos <= CODE_W; pos++) begin
            if (!fim_pkg::is_pow2(pos)) begin
                code[pos-1] = data[d];
                d++;
            end
        end
        for (int k = 0; k < PAR_W; k++) begin
            p = 1'b0;
            for (int pos = 1; pos <= CODE_W; pos++) begin
                if (((pos >> k) & 1) == 1) p = p ^ code[pos-1];
            end
            code[(1 << k) - 1] = p;
        end
    end
endmodule

// File: rtl/fim_ham_dec.sv
module fim_ham_dec #(
    parameter int DATA_W = 8,
    parameter int CODE_W = fim_pkg::code_width(DATA_W)
) (
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        int syn;
        int d;
        logic [CODE_W-1:0] fixed;
        syn = 0;
        for (int pos = 1; pos <= CODE_W; pos++) begin
            if (code[pos-1]) syn = syn ^ pos;
        end
        fixed = code;
        if (syn != 0 && syn <= CODE_W) fixed[syn-1] = ~fixed[syn-1];
        data = '0;
        d    = 0;
        for (int pos = 1; pos <= CODE_W; pos++) begin
            if (!fim_pkg::is_pow2(pos)) begin
                data[d] = fixed[pos-1];
                d++;
            end
        end
    end
endmodule

// File: rtl/fim_dpram.sv
module fim_dpram #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WORD_W-1:0] a_wdata,
    output logic [WORD_W-1:0] a_q,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WORD_W-1:0] b_wdata,
    output logic [WORD_W-1:0] b_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic a_wr, b_wr, clash;

    assign a_wr  = a_en && a_we;
    assign b_wr  = b_en && b_we;
    assign clash = a_wr && b_wr && (a_addr == b_addr);

    always_ff @(posedge clk) begin
        if (b_wr && !clash) mem[b_addr] <= b_wdata;
        if (a_wr)           mem[a_addr] <= a_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (a_en) a_q <= mem[a_addr];
            if (b_en) b_q <= mem[b_addr];
        end
    end
endmodule

// File: rtl/fim_inj_ctrl.sv
module fim_inj_ctrl #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_mask,
    input  logic              core_wr,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [WORD_W-1:0] core_word,
    output logic              b_en,
    output logic              b_we,
    output logic [ADDR_W-1:0] b_addr,
    output logic [WORD_W-1:0] b_wdata,
    input  logic [WORD_W-1:0] b_q,
    output logic              busy,
    output fim_pkg::inj_flags_t flags,
    output logic [ADDR_W-1:0] job_addr
);
    import fim_pkg::*;

    inj_state_e        state;
    logic [WORD_W-1:0] job_mask;
    logic              fwd_vld;
    logic [WORD_W-1:0] fwd_word;
    logic              hit;

    assign hit     = core_wr && (core_addr == job_addr);
    assign busy    = (state != INJ_IDLE);
    assign b_en    = busy;
    assign b_we    = (state == INJ_WRITE);
    assign b_addr  = job_addr;
    assign b_wdata = (fwd_vld ? fwd_word : b_q) ^ job_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= INJ_IDLE;
            job_addr <= '0;
            job_mask <= '0;
            fwd_vld  <= 1'b0;
            fwd_word <= '0;
            flags    <= '0;
        end else begin
            flags <= '0;
            unique case (state)
                INJ_IDLE: begin
                    if (req) begin
                        job_addr <= req_addr;
                        job_mask <= req_mask;
                        state    <= INJ_READ;
                    end
                end
                INJ_READ: begin
                    fwd_vld  <= hit;
                    fwd_word <= core_word;
                    state    <= INJ_WRITE;
                end
                INJ_WRITE: begin
                    flags.done   <= 1'b1;
                    flags.masked <= hit;
                    fwd_vld      <= 1'b0;
                    state        <= INJ_IDLE;
                end
                default: state <= INJ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fim_mem_injector.sv
module fim_mem_injector #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter bit HARDEN = 1'b1,
    parameter int WORD_W = HARDEN ? fim_pkg::code_width(DATA_W) : DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              inj_req,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [WORD_W-1:0] inj_mask,
    output logic              inj_busy,
    output logic              inj_done,
    output logic              inj_masked
);
    logic [WORD_W-1:0] a_word, a_q;
    logic              b_en, b_we;
    logic [ADDR_W-1:0] b_addr;
    logic [WORD_W-1:0] b_wdata, b_q;
    logic [ADDR_W-1:0] job_addr;
    fim_pkg::inj_flags_t flags;

    generate
        if (HARDEN) begin : g_hard
            fim_ham_enc #(.DATA_W(DATA_W), .CODE_W(WORD_W)) u_enc (
                .data(a_wdata), .code(a_word));
            fim_ham_dec #(.DATA_W(DATA_W), .CODE_W(WORD_W)) u_dec (
                .code(a_q), .data(a_rdata));
        end else begin : g_plain
            assign a_word  = a_wdata;
            assign a_rdata = a_q;
        end
    endgenerate

    fim_dpram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_word), .a_q(a_q),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_q(b_q));

    fim_inj_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .req(inj_req), .req_addr(inj_addr), .req_mask(inj_mask),
        .core_wr(a_en && a_we), .core_addr(a_addr), .core_word(a_word),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_q(b_q),
        .busy(inj_busy), .flags(flags), .job_addr(job_addr));

    assign inj_done   = flags.done;
    assign inj_masked = flags.masked;
endmodule

// File: rtl/fim_mem_injector_chk.sv
module fim_mem_injector_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              a_en,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic              inj_req,
    input logic              inj_busy,
    input logic              inj_done,
    input logic              inj_masked,
    input logic [ADDR_W-1:0] job_addr
);
    a_r4_busy_after_req: assert property (@(posedge clk) disable iff (rst)
        (inj_req && !inj_busy) |=> inj_busy);

    a_r4_two_cycle: assert property (@(posedge clk) disable iff (rst)
        $rose(inj_busy) |-> ##2 (inj_done && !inj_busy));

    a_r4_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        inj_done |-> (!inj_busy && $past(inj_busy)));

    a_r6_masked_only_with_done: assert property (@(posedge clk) disable iff (rst)
        inj_masked |-> inj_done);

    a_r6_masked_on_clash: assert property (@(posedge clk) disable iff (rst)
        inj_done |-> (inj_masked == $past(a_en && a_we && (a_addr == job_addr))));
endmodule

bind fim_mem_injector fim_mem_injector_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
    .inj_req(inj_req), .inj_busy(inj_busy), .inj_done(inj_done),
    .inj_masked(inj_masked), .job_addr(job_addr));

// File: tb/fim_mem_injector_tb.sv
module fim_mem_injector_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, a_en, a_we, inj_req;
    logic [7:0]  a_addr, a_wdata, inj_addr, mask_r;
    logic [11:0] mask_h;
    logic [7:0]  rd_h, rd_r;
    logic        busy_h, busy_r, done_h, done_r, msk_h, msk_r;

    fim_mem_injector #(.HARDEN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(rd_h), .inj_req(inj_req), .inj_addr(inj_addr),
        .inj_mask(mask_h), .inj_busy(busy_h), .inj_done(done_h), .inj_masked(msk_h));

    fim_mem_injector #(.HARDEN(1'b0)) u_raw (
        .clk(clk), .rst(rst), .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(rd_r), .inj_req(inj_req), .inj_addr(inj_addr),
        .inj_mask(mask_r), .inj_busy(busy_r), .inj_done(done_r), .inj_masked(msk_r));

    int n_run = 0;
    int n_fail = 0;
    string cur_tag = "R1";
    bit chk_on = 1'b0;

    logic [7:0]  raw_mem  [256];
    logic [7:0]  hard_dat [256];
    logic [11:0] hard_acc [256];
    bit          seen     [256];
    int          ph;
    logic [7:0]  j_addr, j_mr;
    logic [11:0] j_mh;
    logic        e_busy, e_done, e_masked, e_rv, e_hv;
    logic [7:0]  e_rr, e_rh;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: stored bytes plus accumulated flip masks.
    always @(posedge clk) begin
        if (rst) begin
            ph = 0; e_busy = 0; e_done = 0; e_masked = 0; e_rv = 0; e_hv = 0;
        end else begin
            e_rv = 0; e_hv = 0; e_done = 0; e_masked = 0;
            if (a_en && !a_we && seen[a_addr]) begin
                e_rv = 1;
                e_rr = raw_mem[a_addr];
                e_rh = hard_dat[a_addr];
                e_hv = ($countones(hard_acc[a_addr]) <= 1);
            end
            if (ph == 2) begin
                e_done = 1;
                if (a_en && a_we && a_addr == j_addr) e_masked = 1;
                else begin
                    raw_mem[j_addr]  = raw_mem[j_addr] ^ j_mr;
                    hard_acc[j_addr] = hard_acc[j_addr] ^ j_mh;
                end
                ph = 0;
            end else if (ph == 1) begin
                ph = 2;
            end else if (inj_req) begin
                ph = 1; j_addr = inj_addr; j_mr = mask_r; j_mh = mask_h;
            end
            if (a_en && a_we) begin
                raw_mem[a_addr]  = a_wdata;
                hard_dat[a_addr] = a_wdata;
                hard_acc[a_addr] = '0;
                seen[a_addr]     = 1'b1;
            end
            e_busy = (ph != 0);
        end
    end

    always @(negedge clk) begin
        if (chk_on && !rst) begin
            chk("R4", "busy hardened", busy_h, e_busy);
            chk("R4", "busy plain", busy_r, e_busy);
            chk("R4", "done hardened", done_h, e_done);
            chk("R4", "done plain", done_r, e_done);
            chk("R6", "masked hardened", msk_h, e_masked);
            chk("R6", "masked plain", msk_r, e_masked);
            if (e_rv) chk(cur_tag, "plain read", rd_r, e_rr);
            if (e_rv && e_hv) chk((cur_tag == "R3") ? "R8" : cur_tag, "hardened read", rd_h, e_rh);
        end
    end

    task automatic idle();
        @(negedge clk); a_en = 0; a_we = 0; inj_req = 0;
    endtask
    task automatic wr(input logic [7:0] ad, input logic [7:0] d);
        @(negedge clk); a_en = 1; a_we = 1; a_addr = ad; a_wdata = d; inj_req = 0;
    endtask
    task automatic rd(input logic [7:0] ad);
        @(negedge clk); a_en = 1; a_we = 0; a_addr = ad; inj_req = 0;
    endtask
    task automatic inj(input logic [7:0] ad, input logic [11:0] mh, input logic [7:0] mr);
        @(negedge clk); a_en = 0; a_we = 0; inj_req = 1; inj_addr = ad; mask_h = mh; mask_r = mr;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin seen[i] = 0; hard_acc[i] = '0; end
        rst = 1; a_en = 0; a_we = 0; inj_req = 0; a_addr = 0; a_wdata = 0;
        inj_addr = 0; mask_h = 0; mask_r = 0;
        repeat (3) @(negedge clk);
        chk("R9", "busy in reset", busy_h, 0);
        chk("R9", "done in reset", done_h | done_r, 0);
        rst = 0;
        @(negedge clk);
        chk("R9", "busy after reset", busy_h | busy_r, 0);
        chk("R9", "masked after reset", msk_h | msk_r, 0);
        chk("R9", "rdata hardened", rd_h, 0);
        chk("R9", "rdata plain", rd_r, 0);
        chk_on = 1;

        cur_tag = "R2";
        for (int i = 0; i < 256; i++) wr(i[7:0], 8'(i * 3 + 1));
        for (int i = 0; i < 256; i += 17) rd(i[7:0]);
        rd(8'd0); rd(8'd255);

        cur_tag = "R1";
        rd(8'd9); wr(8'd9, 8'h5A); rd(8'd9); idle();

        cur_tag = "R3";
        inj(8'd5, 12'h004, 8'h01); idle(); idle(); rd(8'd5);
        inj(8'd6, 12'h001, 8'h80); idle(); idle(); rd(8'd6);
        inj(8'd255, 12'h800, 8'h10); idle(); idle(); rd(8'd255);
        inj(8'd0, 12'h100, 8'hFF); idle(); idle(); rd(8'd0); idle();

        cur_tag = "R5";
        inj(8'd40, 12'h020, 8'h02); rd(8'd41); wr(8'd42, 8'hC3); rd(8'd42); rd(8'd41); idle();

        cur_tag = "R6";
        inj(8'd60, 12'h040, 8'h04); idle(); wr(8'd60, 8'h77); rd(8'd60); idle();

        cur_tag = "R7";
        inj(8'd70, 12'h200, 8'h20); wr(8'd70, 8'h3C); idle(); rd(8'd70); idle();

        cur_tag = "R4";
        inj(8'd80, 12'h008, 8'h08);
        @(negedge clk); inj_req = 1; inj_addr = 8'd80; mask_h = 12'h008; mask_r = 8'h08;
        @(negedge clk); inj_req = 1;
        rd(8'd80); idle(); idle();
        inj(8'd80, 12'h008, 8'h08); idle(); idle(); rd(8'd80); idle();

        cur_tag = "R8";
        inj(8'd90, 12'h002, 8'h00); idle(); idle(); rd(8'd90);
        inj(8'd91, 12'h080, 8'h00); idle(); idle(); rd(8'd91); idle();

        repeat (3) idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule